// File: doc/BRIEF.md
# Shared-Written Line Classification Coherence Controller

This block keeps the coherence class of every line held in one bank of a shared second-level cache. It does not track a list of sharers. Each line instead carries a presence bit and three state bits: a sticky "shared" flag, a sticky "written" flag, and a flag that says whether the bank holds the line's single exclusivity token. A line is then in one of three classes. Private lines are touched by one core. Read-only shared lines are read by several cores. Shared-and-written lines are banished from the first-level caches and served only by the bank.

First-level caches send one request per cycle. Each request carries an operation, the line index, the core id and a flag that says whether the requester holds the token. Each accepted request gets a registered answer one cycle later. The answer says whether the line may be kept in the first-level cache, whether the token is handed to the requester, and whether a write is acknowledged. When a line first becomes shared-and-written, the block raises a request on a broadcast-invalidate bus. The request is held in the same cycle until it is granted, and the line's state update is committed in the grant cycle. No transient state is ever stored.

Operation encoding on `req_op`: 0 = read, 1 = write notice (write-through or first write), 2 = first-level eviction, 3 = eviction from the bank.

Top module: `swcc_ctrl`

## Requirements
- R1: After reset every line is absent, `rsp_valid` and `bcast_req` are 0, and `req_ready` is 1 while no request is offered. A reset in the middle of operation forgets every line.
- R2: A read (op 0) to an absent line answers cacheable=1, token grant=1, ack=0. The line becomes private and the bank no longer holds the token.
- R3: A write notice (op 1) to an absent line answers cacheable=1, grant=1, ack=1. The line becomes private and written.
- R4: A first-level eviction (op 2) with the token flag set, on a line that is not shared, returns the token to the bank. The next read by any core answers grant=1 and cacheable=1. A first-level eviction without the token flag has no effect. Every eviction response has all three answer bits at 0.
- R5: A read of an unwritten line by a core without the token, while the bank also lacks the token, marks the line shared. It answers cacheable=1, grant=0, with no broadcast. Later reads of that line answer the same way.
- R6: A write notice by the token holder on a private line answers cacheable=1 and grant=0. It answers ack=1 only if the line was not yet written. When the bank holds the token, the writer also gets grant=1.
- R7: A line becomes shared-and-written in three cases: any write to a shared line, a write by a core without the token to a private line, or any access by a core without the token to a private written line (the bank lacking the token in the last two cases). On that transition `bcast_req` is 1 with `bcast_idx` equal to the line. `req_ready` stays 0 until `bcast_gnt`. The response is cacheable=0, grant=0, with ack=1 for a write.
- R8: A shared-and-written line stays so. Later reads answer cacheable=0, grant=0. Later writes answer cacheable=0, ack=1. Neither raises a broadcast, and first-level evictions do not change the line.
- R9: A bank eviction (op 3) clears the line, so the next access behaves as a miss.
- R10: Without a pending broadcast, `req_ready` is 1. Each accepted request gives exactly one response with `rsp_valid`=1 on the next cycle, carrying the requester's id on `rsp_core`. A cycle with no accepted request gives `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | Operation: 0 read, 1 write notice, 2 first-level eviction, 3 bank eviction |
| req_idx | input | IDX_W | Line index |
| req_core | input | CORE_W | Requesting core |
| req_has_tok | input | 1 | Requester holds the line's exclusivity token |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_core | output | CORE_W | Core the response belongs to |
| rsp_cacheable | output | 1 | Line may be kept in the first-level cache |
| rsp_tok_grant | output | 1 | Token handed to the requester |
| rsp_wr_ack | output | 1 | Write acknowledged |
| bcast_req | output | 1 | Broadcast invalidation requested |
| bcast_idx | output | IDX_W | Line to invalidate |
| bcast_gnt | input | 1 | Broadcast bus granted |

## Verification
The assertions assume that the token flag sent by a core matches the state the block handed out. Only the core last granted the token, and only until it evicts, sets `req_has_tok`. They also assume that a request stalled on a broadcast is held unchanged until `req_ready` rises. The stimulus follows each line's token from grant to return, so no core claims a token it does not have. It keeps `req_op`, `req_idx`, `req_core` and `req_has_tok` constant across stalled cycles, withholding `bcast_gnt` for several cycles before granting.

// File: rtl/swcc_pkg.sv
// Shared types for the shared-written classification controller.
// Assumes: operation codes are fixed by the requester interface.
package swcc_pkg;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_WRITE    = 2'd1,
        OP_L1_EVICT = 2'd2,
        OP_L2_EVICT = 2'd3
    } req_op_e;

    // Per-line record: presence, sticky shared, sticky written, token at bank.
    typedef struct packed {
        logic vld;
        logic shr;
        logic wrt;
        logic tok;
    } line_state_t;

endpackage

// File: rtl/swcc_line_table.sv
// Directly indexed table of per-line classification records.
// Assumes: one read port used combinationally, one write per cycle.
module swcc_line_table
    import swcc_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_state_t       rd_state,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_state_t       wr_state
);

    line_state_t ent_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_ent
        logic hit;
        assign hit = we && (wr_idx == IDX_W'(i));

        // Hold one line's record; reset forgets it.
        always_ff @(posedge clk) begin
            if (!rst_n)   ent_q[i] <= '0;
            else if (hit) ent_q[i] <= wr_state;
        end

        // R8
        sticky_srw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && ent_q[i].vld && ent_q[i].shr && ent_q[i].wrt && wr_state.vld)
            |=> (ent_q[i].vld && ent_q[i].shr && ent_q[i].wrt));
    end

    // Read the addressed record.
    assign rd_state = ent_q[rd_idx];

endmodule

// File: rtl/swcc_classify.sv
// Combinational decision for one request against one line record.
// Assumes: has_tok is truthful; record comes from the table this cycle.
module swcc_classify
    import swcc_pkg::*;
(
    input  req_op_e      op,
    input  logic         has_tok,
    input  line_state_t  cur,
    output line_state_t  nxt,
    output logic         need_bcast,
    output logic         cacheable,
    output logic         tok_grant,
    output logic         wr_ack
);

    logic srw;
    logic foreign;

    assign srw     = cur.vld && cur.shr && cur.wrt;
    assign foreign = !has_tok && !cur.tok;

    // Derive next record and answer bits from operation and current class.
    always_comb begin
        nxt        = cur;
        need_bcast = 1'b0;
        cacheable  = 1'b0;
        tok_grant  = 1'b0;
        wr_ack     = 1'b0;
        unique case (op)
            OP_READ: begin
                if (!cur.vld) begin
                    nxt       = '{vld: 1'b1, shr: 1'b0, wrt: 1'b0, tok: 1'b0};
                    cacheable = 1'b1;
                    tok_grant = 1'b1;
                end else if (srw) begin
                    cacheable = 1'b0;
                end else if (cur.tok) begin
                    nxt.tok   = 1'b0;
                    cacheable = 1'b1;
                    tok_grant = 1'b1;
                end else if (has_tok) begin
                    cacheable = 1'b1;
                end else begin
                    nxt.shr = 1'b1;
                    if (cur.wrt) begin
                        nxt.tok    = 1'b1;
                        need_bcast = 1'b1;
                    end else begin
                        cacheable = 1'b1;
                    end
                end
            end
            OP_WRITE: begin
                if (!cur.vld) begin
                    nxt       = '{vld: 1'b1, shr: 1'b0, wrt: 1'b1, tok: 1'b0};
                    cacheable = 1'b1;
                    tok_grant = 1'b1;
                    wr_ack    = 1'b1;
                end else if (srw) begin
                    wr_ack = 1'b1;
                end else if (cur.shr || foreign) begin
                    nxt.shr    = 1'b1;
                    nxt.wrt    = 1'b1;
                    nxt.tok    = 1'b1;
                    need_bcast = 1'b1;
                    wr_ack     = 1'b1;
                end else begin
                    wr_ack    = !cur.wrt;
                    nxt.wrt   = 1'b1;
                    cacheable = 1'b1;
                    if (cur.tok) begin
                        nxt.tok   = 1'b0;
                        tok_grant = 1'b1;
                    end
                end
            end
            OP_L1_EVICT: begin
                if (cur.vld && !cur.shr && has_tok && !cur.tok) nxt.tok = 1'b1;
            end
            OP_L2_EVICT: begin
                nxt = '0;
            end
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/swcc_ctrl.sv
// Per-line shared/written classification controller for one cache bank.
// Takes one request per cycle, answers one cycle later, and holds a
// request that needs a broadcast invalidation until the bus grants it;
// the line update is committed in the grant cycle.
// Assumes: stalled requests are held stable by the requester.
module swcc_ctrl
    import swcc_pkg::*;
#(
    parameter int LINES = 16,
    parameter int CORES = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int CORE_W = $clog2(CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [CORE_W-1:0] req_core,
    input  logic              req_has_tok,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic              rsp_cacheable,
    output logic              rsp_tok_grant,
    output logic              rsp_wr_ack,
    output logic              bcast_req,
    output logic [IDX_W-1:0]  bcast_idx,
    input  logic              bcast_gnt
);

    line_state_t cur_st;
    line_state_t nxt_st;
    logic        need_bcast;
    logic        d_cache;
    logic        d_grant;
    logic        d_ack;
    logic        acc;

    swcc_line_table #(.LINES(LINES)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_state (cur_st),
        .we       (acc),
        .wr_idx   (req_idx),
        .wr_state (nxt_st)
    );

    swcc_classify i_classify (
        .op         (req_op_e'(req_op)),
        .has_tok    (req_has_tok),
        .cur        (cur_st),
        .nxt        (nxt_st),
        .need_bcast (need_bcast),
        .cacheable  (d_cache),
        .tok_grant  (d_grant),
        .wr_ack     (d_ack)
    );

    // Broadcast request and acceptance: stall only while the bus is not granted.
    assign bcast_req = req_valid && need_bcast;
    assign bcast_idx = req_idx;
    assign req_ready = !bcast_req || bcast_gnt;
    assign acc       = req_valid && req_ready;

    // Register the answer for the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_core      <= '0;
            rsp_cacheable <= 1'b0;
            rsp_tok_grant <= 1'b0;
            rsp_wr_ack    <= 1'b0;
        end else begin
            rsp_valid     <= acc;
            rsp_core      <= acc ? req_core : '0;
            rsp_cacheable <= acc && d_cache;
            rsp_tok_grant <= acc && d_grant;
            rsp_wr_ack    <= acc && d_ack;
        end
    end

    // R7
    bcast_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_req && bcast_gnt) |=> (rsp_valid && !rsp_cacheable && !rsp_tok_grant));

    // R2
    grant_cacheable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tok_grant |-> (rsp_valid && rsp_cacheable));

    // R10
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (bcast_req && !bcast_gnt));

    // R6
    ack_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ack |-> ($past(req_op) == 2'd1));

endmodule

// File: tb/test_swcc_ctrl.sv
module test_swcc_ctrl;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] idx;
        logic [1:0] core;
        logic       tok;
        logic       gnt;
        logic       rdy;
        logic       bc;
        logic       cach;
        logic       grt;
        logic       ack;
    } vec_t;

    localparam int NV = 34;
    // op, idx, core, tok, gnt | exp ready, bcast, cacheable, grant, ack
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 miss read
        '{2'd0, 4'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 holder re-read
        '{2'd1, 4'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 first write
        '{2'd1, 4'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 later write
        '{2'd2, 4'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 token return
        '{2'd0, 4'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 bank token granted
        '{2'd0, 4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 stalled
        '{2'd0, 4'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 read of written private
        '{2'd1, 4'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 write
        '{2'd0, 4'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 read
        '{2'd2, 4'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 evict
        '{2'd0, 4'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 still banished
        '{2'd0, 4'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
        '{2'd0, 4'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 shared read
        '{2'd0, 4'd2, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 again
        '{2'd1, 4'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 write to shared
        '{2'd0, 4'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
        '{2'd1, 4'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 foreign write
        '{2'd1, 4'd4, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 miss write
        '{2'd3, 4'd4, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 bank evict
        '{2'd0, 4'd4, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 miss again
        '{2'd0, 4'd5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
        '{2'd2, 4'd5, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 evict without token
        '{2'd0, 4'd5, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 ignored -> shared
        '{2'd3, 4'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 evict banished
        '{2'd0, 4'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 miss again
        '{2'd0, 4'd6, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
        '{2'd2, 4'd6, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 return
        '{2'd0, 4'd6, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 re-grant
        '{2'd1, 4'd6, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R6
        '{2'd0, 4'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
        '{2'd1, 4'd7, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 stall 1
        '{2'd1, 4'd7, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 stall 2
        '{2'd1, 4'd7, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R7 granted
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = '0;
    logic [3:0] req_idx = '0;
    logic [1:0] req_core = '0;
    logic       req_has_tok = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_core;
    logic       rsp_cacheable;
    logic       rsp_tok_grant;
    logic       rsp_wr_ack;
    logic       bcast_req;
    logic [3:0] bcast_idx;
    logic       bcast_gnt = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    swcc_ctrl i_swcc_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_idx(req_idx), .req_core(req_core), .req_has_tok(req_has_tok),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_cacheable(rsp_cacheable),
        .rsp_tok_grant(rsp_tok_grant), .rsp_wr_ack(rsp_wr_ack),
        .bcast_req(bcast_req), .bcast_idx(bcast_idx), .bcast_gnt(bcast_gnt)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid   = 1'b1;
        req_op      = v.op;
        req_idx     = v.idx;
        req_core    = v.core;
        req_has_tok = v.tok;
        bcast_gnt   = v.gnt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1 bcast_req after reset", 32'(bcast_req), 0);
        chk("R1 req_ready idle", 32'(req_ready), 1);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k]);
            #1;
            chk($sformatf("R10/R7 ready vec %0d", k), 32'(req_ready), 32'(VEC[k].rdy));
            chk($sformatf("R7 bcast vec %0d", k), 32'(bcast_req), 32'(VEC[k].bc));
            if (VEC[k].bc)
                chk($sformatf("R7 bcast_idx vec %0d", k), 32'(bcast_idx), 32'(VEC[k].idx));
            @(negedge clk);
            chk($sformatf("R10 rsp_valid vec %0d", k), 32'(rsp_valid), 32'(VEC[k].rdy));
            if (VEC[k].rdy) begin
                chk($sformatf("R10 rsp_core vec %0d", k), 32'(rsp_core), 32'(VEC[k].core));
                chk($sformatf("cacheable vec %0d", k), 32'(rsp_cacheable), 32'(VEC[k].cach));
                chk($sformatf("grant vec %0d", k), 32'(rsp_tok_grant), 32'(VEC[k].grt));
                chk($sformatf("ack vec %0d", k), 32'(rsp_wr_ack), 32'(VEC[k].ack));
            end
        end

        // R10 idle cycle gives no response
        req_valid = 1'b0;
        bcast_gnt = 1'b0;
        @(negedge clk);
        chk("R10 no response when idle", 32'(rsp_valid), 0);
        chk("R10 ready when idle", 32'(req_ready), 1);

        // R1 reset mid-run forgets line 2 (banished before)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        drive('{2'd0, 4'd2, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
        #1;
        chk("R1 no broadcast after reset", 32'(bcast_req), 0);
        @(negedge clk);
        chk("R1 line absent: cacheable", 32'(rsp_cacheable), 1);
        chk("R1 line absent: grant", 32'(rsp_tok_grant), 1);
        req_valid = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule